// File: doc/BRIEF.md
# Transmit Line Diagnostics Monitor

This block watches the line signals of a half-duplex serial transmitter and gives two diagnostics. The first is a reflectometry timer. While the station transmits, the timer counts bit-clock cycles from the moment carrier appears on the line. It stops when a collision is reported or carrier disappears. A short count means a reflection came back from a nearby cable fault, so software can use the value to estimate the distance to the fault. At the end of every transmission the block pulses a write-back strobe, and the counter value is valid while the strobe is high. Software clears the counter with a clear strobe before each packet. The timer never wraps: at all ones it holds.

The second diagnostic is a heartbeat check. After transmit enable falls, a healthy transceiver briefly raises its collision line as a self-test. If no collision is seen inside a fixed window of bit clocks, the block sets a sticky error bit. The same clear strobe clears this bit. The error bit is status only and drives no interrupt.

Timer states: TDR_IDLE (no transmission), TDR_ARMED (transmitting, carrier not yet seen), TDR_RUN (counting), TDR_HELD (counting stopped for the rest of this transmission). Timer transitions: IDLE to ARMED when transmit enable is high. ARMED to RUN when carrier is high and collision is low. RUN to HELD on collision or on loss of carrier. ARMED, RUN or HELD to IDLE when transmit enable is low, and that transition raises the strobe. Heartbeat states: HB_IDLE, HB_TX (transmitting) and HB_LISTEN (window open). Heartbeat transitions: IDLE to TX when transmit enable is high. TX to LISTEN when transmit enable is low. LISTEN to IDLE on collision, which cancels the error. LISTEN to IDLE when the window expires, which sets the error.

Top module: `line_diag_monitor`

## Requirements
- R1: While reset is asserted and after its release, `tdr_count` is 0, `tdr_wb` is 0 and `hb_err` is 0.
- R2: A clock edge that samples `diag_clr` high sets `tdr_count` to 0 and `hb_err` to 0. This takes priority over an increment or an error set at the same edge.
- R3: At every clock edge that samples `tx_en`=1, `carrier`=1 and `coll`=0 in TDR_ARMED or TDR_RUN, `tdr_count` increases by exactly 1. With `tx_en`=0 the count never changes.
- R4: A clock edge in TDR_RUN that samples `coll`=1 stops the count. The count does not restart in that transmission, even when collision clears and carrier stays up.
- R5: A clock edge in TDR_RUN that samples `carrier`=0 stops the count. The count does not restart in that transmission when carrier returns.
- R6: The count saturates at 2^CNT_W-1 (1023 by default) and holds that value until cleared. It never wraps to 0.
- R7: The clock edge that first samples `tx_en`=0 after a transmission raises `tdr_wb` for exactly one cycle. A new transmission does not reset the count; only `diag_clr` does.
- R8: After the edge that first samples `tx_en`=0 (the window opens), if none of the next HB_WINDOW edges (40 by default) samples `coll`=1, `hb_err` is set at the last of those edges and stays set until cleared.
- R9: A collision sampled inside the window cancels the heartbeat error. A collision seen only while `tx_en` is high does not count as a heartbeat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable from the transmitter |
| carrier | input | 1 | Carrier sense from the transceiver |
| coll | input | 1 | Collision indication from the transceiver |
| diag_clr | input | 1 | Clears the timer and the heartbeat error |
| tdr_count | output | CNT_W | Reflectometry timer value |
| tdr_wb | output | 1 | One-cycle end-of-transmission write-back strobe |
| hb_err | output | 1 | Sticky missing-heartbeat error |

## Verification
The timer is driven with several line patterns. A clean carrier ended by a collision shows whether collision freezes the count. A carrier that drops and then returns shows that a stopped count stays stopped. A long unbroken carrier shows whether the count saturates or wraps. A clear pulse in the middle of a run checks clear priority. Carrier with no transmit enable must not move the count. For the heartbeat, collision is placed on the last edge of the window and on the first edge after it, which separates an off-by-one window. Transmissions with a collision only while transmitting, and with none at all, show whether in-transmission collisions are wrongly taken as a heartbeat.

// File: rtl/line_diag_pkg.sv
package line_diag_pkg;

    typedef enum logic [1:0] {
        TDR_IDLE  = 2'd0,
        TDR_ARMED = 2'd1,
        TDR_RUN   = 2'd2,
        TDR_HELD  = 2'd3
    } tdr_state_e;

    typedef enum logic [1:0] {
        HB_IDLE   = 2'd0,
        HB_TX     = 2'd1,
        HB_LISTEN = 2'd2
    } hb_state_e;

endpackage

// File: rtl/tdr_sat_counter.sv
module tdr_sat_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_d;

    // clear wins; an increment at the ceiling leaves the value unchanged
    always_comb begin
        count_d = count_q;
        if (clr) begin
            count_d = '0;
        end else if (inc && (count_q != CNT_MAX)) begin
            count_d = count_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign count = count_q;

endmodule

// File: rtl/tdr_fsm.sv
module tdr_fsm
    import line_diag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic carrier,
    input  logic coll,
    output logic inc,
    output logic wb
);
    tdr_state_e state_q;
    tdr_state_e state_d;
    logic       wb_q;
    logic       wb_d;
    logic       line_clean;

    assign line_clean = carrier && !coll;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TDR_IDLE;
            wb_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            wb_q    <= wb_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        inc     = 1'b0;
        wb_d    = 1'b0;
        unique case (state_q)
            TDR_IDLE: begin
                if (tx_en) begin
                    state_d = TDR_ARMED;
                end
            end
            TDR_ARMED: begin
                if (!tx_en) begin
                    state_d = TDR_IDLE;
                    wb_d    = 1'b1;
                end else if (line_clean) begin
                    state_d = TDR_RUN;
                    inc     = 1'b1;
                end
            end
            TDR_RUN: begin
                if (!tx_en) begin
                    state_d = TDR_IDLE;
                    wb_d    = 1'b1;
                end else if (!line_clean) begin
                    state_d = TDR_HELD;
                end else begin
                    inc = 1'b1;
                end
            end
            TDR_HELD: begin
                if (!tx_en) begin
                    state_d = TDR_IDLE;
                    wb_d    = 1'b1;
                end
            end
            default: begin
                state_d = TDR_IDLE;
            end
        endcase
    end

    assign wb = wb_q;

endmodule

// File: rtl/hb_checker.sv
module hb_checker
    import line_diag_pkg::*;
#(
    parameter int HB_WINDOW = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic coll,
    input  logic clr,
    output logic err
);
    localparam int              WIN_W    = $clog2(HB_WINDOW + 1);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(HB_WINDOW - 1);

    hb_state_e        state_q;
    hb_state_e        state_d;
    logic [WIN_W-1:0] win_q;
    logic [WIN_W-1:0] win_d;
    logic             err_q;
    logic             err_d;
    logic             miss;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HB_IDLE;
            win_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            win_q   <= win_d;
            err_q   <= err_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        win_d   = win_q;
        miss    = 1'b0;
        unique case (state_q)
            HB_IDLE: begin
                if (tx_en) begin
                    state_d = HB_TX;
                end
            end
            HB_TX: begin
                if (!tx_en) begin
                    state_d = HB_LISTEN;
                    win_d   = '0;
                end
            end
            HB_LISTEN: begin
                if (coll) begin
                    state_d = HB_IDLE;
                end else if (win_q == WIN_LAST) begin
                    state_d = HB_IDLE;
                    miss    = 1'b1;
                end else begin
                    win_d = win_q + 1'b1;
                end
            end
            default: begin
                state_d = HB_IDLE;
            end
        endcase

        err_d = err_q;
        if (clr) begin
            err_d = 1'b0;
        end else if (miss) begin
            err_d = 1'b1;
        end
    end

    assign err = err_q;

endmodule

// File: rtl/line_diag_monitor.sv
module line_diag_monitor #(
    parameter int CNT_W     = 10,
    parameter int HB_WINDOW = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             carrier,
    input  logic             coll,
    input  logic             diag_clr,
    output logic [CNT_W-1:0] tdr_count,
    output logic             tdr_wb,
    output logic             hb_err
);
    logic tdr_inc;

    tdr_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_en   (tx_en),
        .carrier (carrier),
        .coll    (coll),
        .inc     (tdr_inc),
        .wb      (tdr_wb)
    );

    tdr_sat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (diag_clr),
        .inc   (tdr_inc),
        .count (tdr_count)
    );

    hb_checker #(.HB_WINDOW(HB_WINDOW)) u_hb (
        .clk   (clk),
        .rst_n (rst_n),
        .tx_en (tx_en),
        .coll  (coll),
        .clr   (diag_clr),
        .err   (hb_err)
    );

endmodule

// File: rtl/line_diag_checks.sv
module line_diag_checks #(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_en,
    input logic             coll,
    input logic             diag_clr,
    input logic [CNT_W-1:0] tdr_count,
    input logic             tdr_wb,
    input logic             hb_err
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        diag_clr |=> (tdr_count == '0) && !hb_err);

    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !diag_clr |=> ((tdr_count == $past(tdr_count)) ||
                       ({1'b0, tdr_count} == {1'b0, $past(tdr_count)} + 1'b1)));

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !diag_clr) |=> $stable(tdr_count));

    assert_coll_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (coll && !diag_clr) |=> $stable(tdr_count));

    assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((tdr_count == TOP) && !diag_clr) |=> (tdr_count == TOP));

    assert_wb_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tdr_wb |=> !tdr_wb);

    assert_hb_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hb_err) |-> ($past(!coll) && $past(!tx_en)));

    assert_hb_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hb_err && !diag_clr) |=> hb_err);

endmodule

bind line_diag_monitor line_diag_checks #(.CNT_W(CNT_W)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .coll      (coll),
    .diag_clr  (diag_clr),
    .tdr_count (tdr_count),
    .tdr_wb    (tdr_wb),
    .hb_err    (hb_err)
);

// File: tb/sim_line_diag_monitor.sv
`timescale 1ns/1ps
module sim_line_diag_monitor;
    localparam int CNT_W = 10;
    localparam int WIN   = 40;
    localparam int TOPV  = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tx_en = 1'b0;
    logic             carrier = 1'b0;
    logic             coll = 1'b0;
    logic             diag_clr = 1'b0;
    logic [CNT_W-1:0] tdr_count;
    logic             tdr_wb;
    logic             hb_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int wb_seen = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_cnt = 0;
    int m_wb  = 0;
    int m_err = 0;
    int m_tx_phase = 0;   // 0 idle, 1 waiting carrier, 2 counting, 3 stopped
    int m_hb_phase = 0;   // 0 idle, 1 sending, 2 listening
    int m_left = 0;

    always #5 clk = ~clk;

    line_diag_monitor #(.CNT_W(CNT_W), .HB_WINDOW(WIN)) u0 (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .carrier(carrier),
        .coll(coll), .diag_clr(diag_clr), .tdr_count(tdr_count),
        .tdr_wb(tdr_wb), .hb_err(hb_err)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // reference model update at each edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_wb = 0; m_err = 0;
            m_tx_phase = 0; m_hb_phase = 0; m_left = 0;
        end else begin
            bit bump;
            bump = 0;
            m_wb = 0;
            if (m_tx_phase == 0) begin
                if (tx_en) m_tx_phase = 1;
            end else if (!tx_en) begin
                m_wb = 1;
                m_tx_phase = 0;
            end else if (m_tx_phase == 1) begin
                if (carrier && !coll) begin bump = 1; m_tx_phase = 2; end
            end else if (m_tx_phase == 2) begin
                if (carrier && !coll) bump = 1;
                else m_tx_phase = 3;
            end
            if (diag_clr) m_cnt = 0;
            else if (bump && m_cnt < TOPV) m_cnt = m_cnt + 1;

            if (m_hb_phase == 0) begin
                if (tx_en) m_hb_phase = 1;
            end else if (m_hb_phase == 1) begin
                if (!tx_en) begin m_hb_phase = 2; m_left = WIN; end
            end else begin
                if (coll) m_hb_phase = 0;
                else begin
                    m_left = m_left - 1;
                    if (m_left == 0) begin
                        m_hb_phase = 0;
                        if (!diag_clr) m_err = 1;
                    end
                end
            end
            if (diag_clr) m_err = 0;
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (tdr_wb) wb_seen++;
        check({cur_req, " count"}, int'(tdr_count), m_cnt);
        check({cur_req, " wb"}, int'(tdr_wb), m_wb);
        check({cur_req, " err"}, int'(hb_err), m_err);
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_clear();
        @(negedge clk); diag_clr = 1'b1;
        @(negedge clk); diag_clr = 1'b0;
    endtask

    initial begin
        cur_req = "R1";
        wait_n(3);
        check("R1 reset count", int'(tdr_count), 0);
        check("R1 reset err", int'(hb_err), 0);
        rst_n = 1'b1;
        wait_n(2);
        check("R1 after release wb", int'(tdr_wb), 0);

        // R4: clean carrier ended by collision, no restart afterwards
        cur_req = "R4";
        pulse_clear();
        tx_en = 1'b1;
        @(negedge clk); carrier = 1'b1;
        wait_n(20);
        coll = 1'b1;
        wait_n(2);
        coll = 1'b0;
        wait_n(5);
        check("R4 frozen at 20", int'(tdr_count), 20);
        wb_seen = 0;
        tx_en = 1'b0; carrier = 1'b0;
        wait_n(5);
        check("R7 one wb pulse", wb_seen, 1);
        coll = 1'b1;
        @(negedge clk); coll = 1'b0;
        wait_n(WIN + 5);
        check("R9 heartbeat seen", int'(hb_err), 0);

        // R7: a new transmission continues from the held value
        cur_req = "R7";
        tx_en = 1'b1;
        @(negedge clk); carrier = 1'b1;
        wait_n(3);
        carrier = 1'b0;
        wait_n(2);
        tx_en = 1'b0;
        wait_n(2);
        check("R7 no auto clear", int'(tdr_count), 23);
        coll = 1'b1;
        @(negedge clk); coll = 1'b0;
        wait_n(WIN + 2);

        // R5: carrier drop then return does not restart
        cur_req = "R5";
        pulse_clear();
        tx_en = 1'b1;
        @(negedge clk); carrier = 1'b1;
        wait_n(7);
        carrier = 1'b0;
        wait_n(3);
        carrier = 1'b1;
        wait_n(4);
        check("R5 stopped at 7", int'(tdr_count), 7);
        tx_en = 1'b0; carrier = 1'b0;

        // R8: no heartbeat at all
        cur_req = "R8";
        wait_n(WIN + 3);
        check("R8 missing heartbeat", int'(hb_err), 1);

        // R2: clear removes error
        cur_req = "R2";
        pulse_clear();
        wait_n(1);
        check("R2 err cleared", int'(hb_err), 0);

        // R8/R9 window edge: collision on last window edge, then one later
        cur_req = "R9";
        tx_en = 1'b1; wait_n(4);
        tx_en = 1'b0;
        wait_n(WIN);
        coll = 1'b1;
        @(negedge clk); coll = 1'b0;
        wait_n(3);
        check("R9 last window edge", int'(hb_err), 0);
        cur_req = "R8";
        tx_en = 1'b1; wait_n(4);
        tx_en = 1'b0;
        wait_n(WIN + 1);
        coll = 1'b1;
        @(negedge clk); coll = 1'b0;
        wait_n(3);
        check("R8 one edge late", int'(hb_err), 1);
        pulse_clear();

        // R9: collision only during transmission is not a heartbeat
        cur_req = "R9";
        tx_en = 1'b1; wait_n(3);
        coll = 1'b1; wait_n(2); coll = 1'b0;
        wait_n(3);
        tx_en = 1'b0;
        wait_n(WIN + 3);
        check("R9 in-tx collision ignored", int'(hb_err), 1);
        pulse_clear();

        // R3: carrier without transmit enable does not count
        cur_req = "R3";
        carrier = 1'b1;
        wait_n(10);
        carrier = 1'b0;
        check("R3 no tx no count", int'(tdr_count), 0);

        // R2: clear in the middle of a run, then R6 saturation
        cur_req = "R2";
        tx_en = 1'b1;
        @(negedge clk); carrier = 1'b1;
        wait_n(10);
        diag_clr = 1'b1;
        @(negedge clk); diag_clr = 1'b0;
        wait_n(5);
        check("R2 clear mid run", int'(tdr_count), 5);
        cur_req = "R6";
        wait_n(TOPV + 50);
        check("R6 saturated", int'(tdr_count), TOPV);
        tx_en = 1'b0; carrier = 1'b0;
        wait_n(2);
        check("R6 held after tx", int'(tdr_count), TOPV);
        coll = 1'b1;
        @(negedge clk); coll = 1'b0;
        wait_n(5);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule